// File: doc/BRIEF.md
# Reset and Output Enable Sequencer

This block sits between the board-level reset and drive-enable pins of a 64-stream serial switch and the logic behind them. An active-low reset pin clears the internal state at once, with no clock needed. The internal reset is released only after the pin has been held low long enough to count as a real reset, and the release is aligned to the input clock. After the release, a host-ready flag stays low for a fixed settling window. This window lets the frame timing logic find the frame pulse format before any host access.

The serial outputs form two groups, local and backplane. Each group is enabled only when the core is out of reset and the synchronised drive-enable pin is high. A disabled group idles in the level its own select pin chooses: driven high, or high impedance. The downstream pad logic reads the per-group drive enable and tri-state controls.

Top module: `rst_oe_sequencer`

## Requirements
- R1: A low level on `rst_pin_n` forces `core_rst_n`, `host_ready`, `loc_drive_en` and `bp_drive_en` low at once, without waiting for a clock edge.
- R2: After `rst_pin_n` has been sampled low on at least two consecutive rising edges of `clk`, its return high makes `core_rst_n` rise on the third rising edge after the pin rises, and not earlier.
- R3: If `rst_pin_n` is sampled low on fewer than two consecutive rising edges, `core_rst_n` stays low and does not rise until a later low period of at least two sampled edges ends.
- R4: `host_ready` rises exactly HOLD_CYC rising edges after `core_rst_n` rises (HOLD_CYC = CLK_KHZ*HOLD_US/1000, 2000 by default) and stays high until the next reset.
- R5: Any reset, including a too-short pulse, clears `host_ready`, and the next release restarts the full HOLD_CYC count.
- R6: While out of reset, a change on `drv_en_pin` appears on both `loc_drive_en` and `bp_drive_en` after the second rising edge of `clk`.
- R7: A group whose drive enable is 0 idles high impedance (`*_hiz` = 1) if its select pin is 1, or driven high (`*_hiz` = 0) if it is 0. Each group follows only its own select. A group whose drive enable is 1 has `*_hiz` = 0.
- R8: While `core_rst_n` is low, both drive enables stay 0 whatever the level of `drv_en_pin`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_pin_n | input | 1 | Asynchronous active-low reset pin |
| drv_en_pin | input | 1 | Output drive enable pin, asynchronous |
| loc_float_sel | input | 1 | Local group idle level: 1 high impedance, 0 driven high |
| bp_float_sel | input | 1 | Backplane group idle level: 1 high impedance, 0 driven high |
| core_rst_n | output | 1 | Synchronised internal reset, active low |
| loc_drive_en | output | 1 | Local streams drive data |
| loc_hiz | output | 1 | Local pads tri-stated |
| bp_drive_en | output | 1 | Backplane streams drive data |
| bp_hiz | output | 1 | Backplane pads tri-stated |
| host_ready | output | 1 | Host access permitted |

## Verification
The reset pin is driven with low pulses of one cycle, exactly two cycles and several cycles, and with a drop in the middle of a clock phase. These patterns separate a qualified reset, a rejected glitch and the asynchronous assertion path. Each release is timed edge by edge against both the core release and the full settling count, so the check catches a count that is too short, too long or not restarted. Random drive-enable and select sequences, compared against a two-edge delayed model, show whether the enable latency is right and whether each group takes its idle level from its own select only.

// File: rtl/rso_pkg.sv
package rso_pkg;
    localparam int unsigned NUM_SIDES = 2;
    localparam int unsigned SIDE_LOC  = 0;
    localparam int unsigned SIDE_BP   = 1;
endpackage

// File: rtl/rso_pin_qual.sv
module rso_pin_qual #(
    parameter int unsigned MIN_LOW     = 2,
    parameter int unsigned PIN_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_pin_n,
    output logic rel_o
);
    localparam int unsigned RW = $clog2(MIN_LOW + 1);

    typedef struct packed {
        logic [PIN_STAGES-1:0] samp;
        logic [RW-1:0]         run;
        logic                  armed;
    } qual_t;

    qual_t qual_d, qual_q;
    logic  rel_d, rel_q;
    logic  pin_s;

    assign pin_s = qual_q.samp[PIN_STAGES-1];

    always_comb begin
        qual_d      = qual_q;
        qual_d.samp = {qual_q.samp[PIN_STAGES-2:0], rst_pin_n};
        if (!pin_s) begin
            if (qual_q.run < RW'(MIN_LOW)) begin
                qual_d.run = qual_q.run + RW'(1);
            end
            if (qual_q.run >= RW'(MIN_LOW - 1)) begin
                qual_d.armed = 1'b1;
            end
        end else begin
            qual_d.run = '0;
            if (rel_q) begin
                qual_d.armed = 1'b0;
            end
        end
        rel_d = rel_q | (pin_s & qual_q.armed);
    end

    // Sampling and qualification state runs on the clock alone so that it
    // can measure how long the pin stays low.
    always_ff @(posedge clk) begin
        qual_q <= qual_d;
    end

    always_ff @(posedge clk or negedge rst_pin_n) begin
        if (!rst_pin_n) begin
            rel_q <= 1'b0;
        end else begin
            rel_q <= rel_d;
        end
    end

    assign rel_o = rel_q;
endmodule

// File: rtl/rso_holdoff.sv
module rso_holdoff #(
    parameter int unsigned HOLD_CYC = 2000
) (
    input  logic clk,
    input  logic rst_pin_n,
    input  logic rel,
    output logic ready_o
);
    localparam int unsigned CW = $clog2(HOLD_CYC + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          ready;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (rel && !hold_q.ready) begin
            hold_d.cnt = hold_q.cnt + CW'(1);
            if (hold_q.cnt == CW'(HOLD_CYC - 1)) begin
                hold_d.ready = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_pin_n) begin
        if (!rst_pin_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign ready_o = hold_q.ready;
endmodule

// File: rtl/rso_drive_ctl.sv
module rso_drive_ctl #(
    parameter int unsigned EN_STAGES = 2,
    parameter int unsigned SIDES     = rso_pkg::NUM_SIDES
) (
    input  logic             clk,
    input  logic             rst_pin_n,
    input  logic             rel,
    input  logic             drv_en_pin,
    input  logic [SIDES-1:0] float_sel,
    output logic [SIDES-1:0] drive_en,
    output logic [SIDES-1:0] hiz
);
    typedef struct packed {
        logic [EN_STAGES-1:0] sync;
    } en_t;

    en_t  en_d, en_q;
    logic en_s;

    always_comb begin
        en_d      = en_q;
        en_d.sync = {en_q.sync[EN_STAGES-2:0], drv_en_pin};
    end

    always_ff @(posedge clk or negedge rst_pin_n) begin
        if (!rst_pin_n) begin
            en_q <= '0;
        end else begin
            en_q <= en_d;
        end
    end

    assign en_s = en_q.sync[EN_STAGES-1];

    for (genvar g = 0; g < SIDES; g++) begin : g_side
        assign drive_en[g] = en_s & rel;
        assign hiz[g]      = ~drive_en[g] & float_sel[g];
    end
endmodule

// File: rtl/rst_oe_sequencer.sv
module rst_oe_sequencer #(
    parameter int unsigned CLK_KHZ     = 8000,
    parameter int unsigned HOLD_US     = 250,
    parameter int unsigned MIN_LOW     = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_pin_n,
    input  logic drv_en_pin,
    input  logic loc_float_sel,
    input  logic bp_float_sel,
    output logic core_rst_n,
    output logic loc_drive_en,
    output logic loc_hiz,
    output logic bp_drive_en,
    output logic bp_hiz,
    output logic host_ready
);
    import rso_pkg::*;

    localparam int unsigned HOLD_CYC = (CLK_KHZ * HOLD_US) / 1000;

    logic                 rel;
    logic [NUM_SIDES-1:0] sel_v, drv_v, hiz_v;

    rso_pin_qual #(
        .MIN_LOW    (MIN_LOW),
        .PIN_STAGES (SYNC_STAGES)
    ) u_qual (
        .clk       (clk),
        .rst_pin_n (rst_pin_n),
        .rel_o     (rel)
    );

    rso_holdoff #(
        .HOLD_CYC (HOLD_CYC)
    ) u_hold (
        .clk       (clk),
        .rst_pin_n (rst_pin_n),
        .rel       (rel),
        .ready_o   (host_ready)
    );

    assign sel_v[SIDE_LOC] = loc_float_sel;
    assign sel_v[SIDE_BP]  = bp_float_sel;

    rso_drive_ctl #(
        .EN_STAGES (SYNC_STAGES),
        .SIDES     (NUM_SIDES)
    ) u_drv (
        .clk        (clk),
        .rst_pin_n  (rst_pin_n),
        .rel        (rel),
        .drv_en_pin (drv_en_pin),
        .float_sel  (sel_v),
        .drive_en   (drv_v),
        .hiz        (hiz_v)
    );

    assign core_rst_n   = rel;
    assign loc_drive_en = drv_v[SIDE_LOC];
    assign loc_hiz      = hiz_v[SIDE_LOC];
    assign bp_drive_en  = drv_v[SIDE_BP];
    assign bp_hiz       = hiz_v[SIDE_BP];
endmodule

// File: rtl/rst_oe_sequencer_chk.sv
module rst_oe_sequencer_chk #(
    parameter int unsigned HOLD_CYC = 2000
) (
    input logic clk,
    input logic rst_pin_n,
    input logic loc_float_sel,
    input logic bp_float_sel,
    input logic core_rst_n,
    input logic loc_drive_en,
    input logic loc_hiz,
    input logic bp_drive_en,
    input logic bp_hiz,
    input logic host_ready
);
    logic [31:0] since_rel;

    always_ff @(posedge clk or negedge rst_pin_n) begin
        if (!rst_pin_n) begin
            since_rel <= '0;
        end else if (!core_rst_n) begin
            since_rel <= '0;
        end else if (since_rel != 32'hFFFF_FFFF) begin
            since_rel <= since_rel + 32'd1;
        end
    end

    // R2
    release_after_pin_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
        $rose(core_rst_n) |-> $past(rst_pin_n));

    // R4
    ready_window_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
        $rose(host_ready) |-> since_rel == HOLD_CYC);

    // R4
    ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
        host_ready |=> host_ready);

    // R5
    ready_needs_core_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
        host_ready |-> core_rst_n);

    // R8
    drive_needs_core_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
        (loc_drive_en || bp_drive_en) |-> core_rst_n);

    // R6
    sides_agree_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
        loc_drive_en == bp_drive_en);

    // R7
    loc_idle_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
        loc_hiz == (!loc_drive_en && loc_float_sel));

    // R7
    bp_idle_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
        bp_hiz == (!bp_drive_en && bp_float_sel));
endmodule

bind rst_oe_sequencer rst_oe_sequencer_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (
    .clk           (clk),
    .rst_pin_n     (rst_pin_n),
    .loc_float_sel (loc_float_sel),
    .bp_float_sel  (bp_float_sel),
    .core_rst_n    (core_rst_n),
    .loc_drive_en  (loc_drive_en),
    .loc_hiz       (loc_hiz),
    .bp_drive_en   (bp_drive_en),
    .bp_hiz        (bp_hiz),
    .host_ready    (host_ready)
);

// File: tb/rst_oe_sequencer_tb.sv
module rst_oe_sequencer_tb;
    localparam int HOLD = 2000;

    logic clk = 1'b0;
    logic rst_pin_n = 1'b0;
    logic drv_en_pin = 1'b0;
    logic loc_float_sel = 1'b1;
    logic bp_float_sel = 1'b0;
    logic core_rst_n, loc_drive_en, loc_hiz, bp_drive_en, bp_hiz, host_ready;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rst_oe_sequencer u_dut (
        .clk           (clk),
        .rst_pin_n     (rst_pin_n),
        .drv_en_pin    (drv_en_pin),
        .loc_float_sel (loc_float_sel),
        .bp_float_sel  (bp_float_sel),
        .core_rst_n    (core_rst_n),
        .loc_drive_en  (loc_drive_en),
        .loc_hiz       (loc_hiz),
        .bp_drive_en   (bp_drive_en),
        .bp_hiz        (bp_hiz),
        .host_ready    (host_ready)
    );

    function automatic logic exp_hiz(logic drv, logic sel);
        return drv ? 1'b0 : sel;
    endfunction

    task automatic chk(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic chk_disabled(string req);
        chk(req, "core_rst_n", core_rst_n, 1'b0);
        chk(req, "host_ready", host_ready, 1'b0);
        chk(req, "loc_drive_en", loc_drive_en, 1'b0);
        chk(req, "bp_drive_en", bp_drive_en, 1'b0);
        chk(req, "loc_hiz", loc_hiz, exp_hiz(1'b0, loc_float_sel));
        chk(req, "bp_hiz", bp_hiz, exp_hiz(1'b0, bp_float_sel));
    endtask

    // Pin rises at a falling edge; core release and full settling count follow.
    task automatic release_and_time();
        rst_pin_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R2", "core_rst_n before third edge", core_rst_n, 1'b0);
        @(negedge clk);
        chk("R2", "core_rst_n at third edge", core_rst_n, 1'b1);
        chk("R8", "drive follows pin after release", loc_drive_en, drv_en_pin);
        repeat (HOLD - 1) @(negedge clk);
        chk("R4", "host_ready one edge early", host_ready, 1'b0);
        @(negedge clk);
        chk("R4", "host_ready at full count", host_ready, 1'b1);
    endtask

    initial begin
        void'($urandom(32'd1234));
        #1;
        // R1: reset state with pin low from time zero
        chk_disabled("R1");
        repeat (4) @(negedge clk);
        chk_disabled("R1");
        release_and_time();

        // R6 R7: random enable and select traffic against a two-edge model
        begin
            logic h1 = drv_en_pin;
            logic h2 = drv_en_pin;
            for (int i = 0; i < 400; i++) begin
                @(negedge clk);
                chk("R6", "loc_drive_en", loc_drive_en, h2);
                chk("R6", "bp_drive_en", bp_drive_en, h2);
                chk("R7", "loc_hiz", loc_hiz, exp_hiz(h2, loc_float_sel));
                chk("R7", "bp_hiz", bp_hiz, exp_hiz(h2, bp_float_sel));
                chk("R4", "host_ready held", host_ready, 1'b1);
                h2 = h1;
                drv_en_pin = 1'($urandom_range(0, 3) != 0);
                h1 = drv_en_pin;
                if ($urandom_range(0, 7) == 0) loc_float_sel = 1'($urandom());
                if ($urandom_range(0, 7) == 0) bp_float_sel = 1'($urandom());
            end
        end

        // R1 R8: asynchronous drop in mid phase with the enable pin high
        drv_en_pin = 1'b1;
        loc_float_sel = 1'b0;
        bp_float_sel = 1'b1;
        repeat (3) @(negedge clk);
        #3 rst_pin_n = 1'b0;
        #1 chk_disabled("R1");
        @(negedge clk);
        chk_disabled("R8");
        @(negedge clk);
        chk_disabled("R8");
        release_and_time();

        // R3 R5: a one-cycle glitch leaves the core held and the flag cleared
        @(negedge clk);
        rst_pin_n = 1'b0;
        #1 chk("R5", "host_ready cleared by glitch", host_ready, 1'b0);
        @(negedge clk);
        rst_pin_n = 1'b1;
        repeat (60) @(negedge clk);
        chk("R3", "core held after glitch", core_rst_n, 1'b0);
        chk("R3", "host_ready after glitch", host_ready, 1'b0);
        chk("R8", "drive off while held", loc_drive_en, 1'b0);

        // R2 R5: a pulse of exactly two edges qualifies and restarts the count
        rst_pin_n = 1'b0;
        repeat (2) @(negedge clk);
        release_and_time();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule